// File: doc/BRIEF.md
# Triggered Circular Trace Buffer

This block is an on-chip debug recorder. It writes one 36-bit entry into a circular RAM for each cycle that carries a valid sample. Before any trigger, the write pointer runs freely around the RAM, so the oldest entries are overwritten. A trigger pulse starts a bounded post-trigger phase. The block writes a fixed number of further valid samples and then freezes, which keeps the entry captured at the trigger intact. A rearm input releases the freeze and restarts free-running capture.

Each entry packs a decoded instruction in one of two forms, chosen by an illegal flag:

- **Legal instruction:** a 9-bit instruction code plus the low 26 instruction bits.
- **Illegal instruction:** the full 32-bit instruction word.

Software dumps the buffer through a plain address/data read port. It also reads the live write pointer, the index where the trigger landed, and a frozen flag.

Top module: `trace_log`

## Requirements
- R1: After reset, `wr_ptr` is 0, `trig_idx` is 0 and `frozen` is 0.
- R2: In a cycle with `smp_valid`=1 while not frozen, the packed entry is written at `wr_ptr`, and `wr_ptr` advances by one on the next edge. When `smp_valid`=0, nothing is written and `wr_ptr` holds.
- R3: `wr_ptr` wraps from DEPTH-1 to 0, and capture continues over the oldest entries.
- R4: A legal sample (`smp_illegal`=0) is stored with the following layout:
  - bit 35 = 0
  - bits 34:26 = `smp_code`
  - bits 25:0 = `smp_insn[25:0]`
- R5: An illegal sample (`smp_illegal`=1) is stored with the following layout:
  - bit 35 = 1
  - bits 34:32 = 0
  - bits 31:0 = `smp_insn`
- R6: A trigger seen while free-running latches the current `wr_ptr` into `trig_idx`. If that cycle also has a valid sample, the trigger sample is stored at that index.
- R7: After the trigger cycle, exactly POST = min(DEPTH/4, 256) further valid samples are written, and then `frozen` becomes 1. With a valid trigger sample, the final `wr_ptr` is `trig_idx`+1+POST modulo DEPTH. The entry at `trig_idx` is never overwritten.
- R8: While frozen, valid samples are not written and `wr_ptr` stays stable.
- R9: Triggers during the post-trigger phase or while frozen are ignored. `trig_idx` and the freeze point are unchanged by them.
- R10: `rearm`=1 clears `frozen` and the post-trigger count at the next edge, and capture resumes. A trigger in the same cycle as `rearm` is ignored.
- R11: `rd_data` shows the entry at `rd_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_illegal | input | 1 | Sample is an illegal instruction |
| smp_code | input | 9 | Instruction code of a legal sample |
| smp_insn | input | 32 | Raw instruction word |
| trig | input | 1 | Trigger pulse |
| rearm | input | 1 | Release freeze and restart capture |
| rd_addr | input | $clog2(DEPTH) | Read address |
| rd_data | output | 36 | Entry at the registered read address |
| wr_ptr | output | $clog2(DEPTH) | Next write index |
| trig_idx | output | $clog2(DEPTH) | Index latched at the trigger |
| frozen | output | 1 | Capture stopped after the post-trigger window |

## Verification
The bench targets the following corner cases:

- **Exact freeze point.** A counter that is off by one would freeze one sample early or late, so the final `wr_ptr` would miss `trig_idx`+1+POST.
- **Trigger pulses repeated through the post-trigger window.** A design that re-latched on them would move `trig_idx` and push the freeze point past the trigger entry.
- **Pointer wrap.** Free-running capture takes `wr_ptr` through the wrap.
- **Triggers in cycles with no valid sample.** These shift the freeze point by one entry compared with a valid trigger sample.
- **Rearm together with a trigger.** A design that gave the trigger priority would re-enter the post-trigger phase at once.
- **Both entry forms with all-ones and mixed instruction words.** A packer that swapped fields or let the upper code bits leak into the illegal form would be caught on read-back.

// File: rtl/trace_pkg.sv
package trace_pkg;
    localparam int ENTRY_W = 36;
    localparam int CODE_W  = 9;
    localparam int LOW_W   = 26;
    localparam int INSN_W  = 32;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_POST = 2'd1,
        ST_HOLD = 2'd2
    } cap_state_e;
endpackage

// File: rtl/trace_pack.sv
module trace_pack
    import trace_pkg::*;
(
    input  logic                illegal,
    input  logic [CODE_W-1:0]   code,
    input  logic [INSN_W-1:0]   insn,
    output logic [ENTRY_W-1:0]  entry
);
    localparam int PAD_W = ENTRY_W - 1 - INSN_W;

    always_comb begin
        if (illegal) begin
            entry = {1'b1, {PAD_W{1'b0}}, insn};
        end else begin
            entry = {1'b0, code, insn[LOW_W-1:0]};
        end
    end
endmodule

// File: rtl/trace_ram.sv
module trace_ram #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 36,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
    import trace_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int POST = (DEPTH / 4 < 256) ? DEPTH / 4 : 256,
    localparam int CW   = $clog2(POST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic          trig,
    input  logic          rearm,
    output logic          we,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] trig_idx,
    output logic          frozen
);
    typedef struct packed {
        cap_state_e    st;
        logic [AW-1:0] wp;
        logic [AW-1:0] tidx;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t r_q, r_d;
    logic  we_d;

    always_comb begin
        r_d  = r_q;
        we_d = valid && (r_q.st != ST_HOLD);
        if (we_d) begin
            r_d.wp = r_q.wp + 1'b1;
        end
        if (rearm) begin
            r_d.st  = ST_RUN;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                ST_RUN: begin
                    if (trig) begin
                        r_d.st   = ST_POST;
                        r_d.tidx = r_q.wp;
                        r_d.cnt  = '0;
                    end
                end
                ST_POST: begin
                    if (we_d) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (r_q.cnt == CW'(POST - 1)) begin
                            r_d.st = ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_RUN, wp: '0, tidx: '0, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign we       = we_d;
    assign wr_ptr   = r_q.wp;
    assign trig_idx = r_q.tidx;
    assign frozen   = (r_q.st == ST_HOLD);
endmodule

// File: rtl/trace_log.sv
module trace_log
    import trace_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic                smp_illegal,
    input  logic [CODE_W-1:0]   smp_code,
    input  logic [INSN_W-1:0]   smp_insn,
    input  logic                trig,
    input  logic                rearm,
    input  logic [AW-1:0]       rd_addr,
    output logic [ENTRY_W-1:0]  rd_data,
    output logic [AW-1:0]       wr_ptr,
    output logic [AW-1:0]       trig_idx,
    output logic                frozen
);
    logic                we;
    logic [ENTRY_W-1:0]  entry;

    trace_pack u_pack (
        .illegal (smp_illegal),
        .code    (smp_code),
        .insn    (smp_insn),
        .entry   (entry)
    );

    trace_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (smp_valid),
        .trig     (trig),
        .rearm    (rearm),
        .we       (we),
        .wr_ptr   (wr_ptr),
        .trig_idx (trig_idx),
        .frozen   (frozen)
    );

    trace_ram #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_ram (
        .clk   (clk),
        .we    (we),
        .waddr (wr_ptr),
        .wdata (entry),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/trace_log_chk.sv
module trace_log_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic          trig,
    input logic          rearm,
    input logic [AW-1:0] wr_ptr,
    input logic [AW-1:0] trig_idx,
    input logic          frozen
);
    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !frozen) |=> (wr_ptr == AW'($past(wr_ptr) + 1'b1)));

    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid || frozen) |=> (wr_ptr == $past(wr_ptr)));

    p_stay_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !rearm) |=> frozen);

    p_rearm_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> !frozen);

    p_freeze_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frozen) |-> $past(smp_valid));

    p_tidx_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(trig_idx) |-> ($past(trig) && !$past(rearm) && !$past(frozen)
                                && trig_idx == $past(wr_ptr)));

    p_tidx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(trig_idx));
endmodule

bind trace_log trace_log_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_valid(smp_valid),
    .trig     (trig),
    .rearm    (rearm),
    .wr_ptr   (wr_ptr),
    .trig_idx (trig_idx),
    .frozen   (frozen)
);

// File: tb/sim_trace_log.sv
module sim_trace_log;
    localparam int DEPTH = 256;
    localparam int AW    = $clog2(DEPTH);
    localparam int POST  = (DEPTH / 4 < 256) ? DEPTH / 4 : 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic          smp_illegal = 1'b0;
    logic [8:0]    smp_code = '0;
    logic [31:0]   smp_insn = '0;
    logic          trig = 1'b0;
    logic          rearm = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [35:0]   rd_data;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] trig_idx;
    logic          frozen;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [35:0] m_mem [DEPTH];
    bit          m_ok  [DEPTH];
    int          m_wp   = 0;
    int          m_st   = 0;
    int          m_cnt  = 0;
    int          m_tidx = 0;

    always #10 clk = ~clk;

    trace_log #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_illegal(smp_illegal),
        .smp_code(smp_code), .smp_insn(smp_insn), .trig(trig), .rearm(rearm),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_ptr(wr_ptr),
        .trig_idx(trig_idx), .frozen(frozen)
    );

    function automatic logic [35:0] exp_pack(bit il, logic [8:0] cd, logic [31:0] in);
        if (il) return {1'b1, 3'b000, in};
        return {1'b0, cd, in[25:0]};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(bit v, bit il, logic [8:0] cd, logic [31:0] in, bit tg, bit ra);
        bit we;
        int old_wp;
        smp_valid = v; smp_illegal = il; smp_code = cd; smp_insn = in;
        trig = tg; rearm = ra;
        we = v && (m_st != 2);
        old_wp = m_wp;
        if (we) begin
            m_mem[m_wp] = exp_pack(il, cd, in);
            m_ok[m_wp]  = 1'b1;
            m_wp = (m_wp + 1) % DEPTH;
        end
        if (ra) begin
            m_st = 0; m_cnt = 0;
        end else if (m_st == 0 && tg) begin
            m_st = 1; m_tidx = old_wp; m_cnt = 0;
        end else if (m_st == 1 && we) begin
            m_cnt++;
            if (m_cnt == POST) m_st = 2;
        end
        @(negedge clk);
        chk("R2/R3 wr_ptr", 64'(wr_ptr), 64'(m_wp));
        chk("R7/R8 frozen", 64'(frozen), 64'(m_st == 2));
        chk("R6/R9 trig_idx", 64'(trig_idx), 64'(m_tidx));
    endtask

    task automatic rnd_cyc(int trig_pct, int rearm_pct);
        cyc(($urandom % 100) < 70, ($urandom % 4) == 0, 9'($urandom), $urandom,
            ($urandom % 100) < trig_pct, ($urandom % 100) < rearm_pct);
    endtask

    task automatic idle();
        smp_valid = 1'b0; trig = 1'b0; rearm = 1'b0;
    endtask

    task automatic read_at(int a, string tag, logic [35:0] exp);
        idle();
        rd_addr = AW'(a);
        @(negedge clk);
        chk(tag, 64'(rd_data), 64'(exp));
    endtask

    task automatic dump(string tag);
        for (int a = 0; a < DEPTH; a++) begin
            if (m_ok[a]) read_at(a, tag, m_mem[a]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int t;
        void'($urandom(32'd20240611));
        for (int a = 0; a < DEPTH; a++) m_ok[a] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 wr_ptr", 64'(wr_ptr), 64'd0);
        chk("R1 trig_idx", 64'(trig_idx), 64'd0);
        chk("R1 frozen", 64'(frozen), 64'd0);

        // R2 R3: free running capture across the wrap
        for (int i = 0; i < 600; i++) rnd_cyc(0, 0);
        dump("R4/R5/R11 free-run readback");

        // R4 R5 directed encodings
        t = m_wp;
        cyc(1'b1, 1'b0, 9'h1A5, 32'hFFFF_FFFF, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 9'h1FF, 32'hDEAD_BEEF, 1'b0, 1'b0);
        read_at(t, "R4 legal layout", {1'b0, 9'h1A5, 26'h3FF_FFFF});
        read_at((t + 1) % DEPTH, "R5 illegal layout", 36'h8_DEAD_BEEF);

        // R6 R7 R9: valid trigger, trigger pulses repeated in window
        t = m_wp;
        cyc(1'b1, 1'b0, 9'h0AA, 32'h1234_5678, 1'b1, 1'b0);
        chk("R6 trig_idx latched", 64'(trig_idx), 64'(t));
        for (int i = 0; i < POST; i++) begin
            chk("R7 not frozen early", 64'(frozen), 64'd0);
            cyc(1'b1, 1'b0, 9'($urandom), $urandom, 1'b1, 1'b0);
        end
        chk("R7 frozen at window end", 64'(frozen), 64'd1);
        chk("R7 final wr_ptr", 64'(wr_ptr), 64'((t + 1 + POST) % DEPTH));
        chk("R9 trig_idx kept", 64'(trig_idx), 64'(t));
        // R8: valid samples while frozen are dropped
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b1, 9'h0, $urandom, 1'b1, 1'b0);
        chk("R8 wr_ptr stable", 64'(wr_ptr), 64'((t + 1 + POST) % DEPTH));
        read_at(t, "R7 trigger entry intact", {1'b0, 9'h0AA, 26'(32'h1234_5678)});
        dump("R7/R8/R11 frozen readback");

        // R10: rearm together with trigger
        cyc(1'b1, 1'b0, 9'h3, 32'h3, 1'b1, 1'b1);
        chk("R10 released", 64'(frozen), 64'd0);
        chk("R10 trigger ignored", 64'(trig_idx), 64'(t));

        // R6 R7: trigger in a cycle with no valid sample
        t = m_wp;
        cyc(1'b0, 1'b0, 9'h0, 32'h0, 1'b1, 1'b0);
        for (int i = 0; i < POST; i++) cyc(1'b1, 1'b0, 9'($urandom), $urandom, 1'b0, 1'b0);
        chk("R7 no-sample trigger freeze ptr", 64'(wr_ptr), 64'((t + POST) % DEPTH));
        chk("R7 no-sample frozen", 64'(frozen), 64'd1);

        // R10: rearm in the middle of a window
        cyc(1'b0, 1'b0, 9'h0, 32'h0, 1'b0, 1'b1);
        cyc(1'b1, 1'b0, 9'h1, 32'h1, 1'b1, 1'b0);
        for (int i = 0; i < POST / 2; i++) rnd_cyc(0, 0);
        cyc(1'b1, 1'b0, 9'h2, 32'h2, 1'b0, 1'b1);
        for (int i = 0; i < POST; i++) rnd_cyc(0, 0);
        chk("R10 mid-window rearm keeps running", 64'(frozen), 64'd0);

        // mixed random
        for (int i = 0; i < 4000; i++) rnd_cyc(3, 1);
        dump("R2/R4/R5/R11 random readback");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule